// File: doc/BRIEF.md
# Half-Duplex Smart Card Character Transceiver

This block moves byte characters between a host and a contact smart card over one shared open-drain data line. The line is either released, so that a pull-up holds it high, or pulled low. Transmit bytes wait in an 8-entry queue. Whenever both engines are idle, the transmitter takes the oldest byte and shifts it out as an 11-slot character: a low start slot, eight data slots with the least significant bit first, a parity slot, and a released stop slot.

The receiver only listens while the transmitter is idle. It treats a low level on the line as a possible start. It confirms the start at the middle of the slot, samples the middle of every later slot, and places the rebuilt byte in an 8-entry receive queue. At the same time it checks the parity and the stop level.

Two inputs set the line behaviour: a slot length in clock cycles (372 is the usual value) and a parity sense. The outputs are the line drive and a set of line-status flags. The error flags stay set until a clear pulse. The pad is modelled as a separate sampled input (`io_in`) and a pull-low enable (`io_drive_low`).

Top module: `sc_char_xcvr`

## Requirements
- R1: A transmitted character holds each of its 11 slots for `etu_cycles` clock cycles. In order, the slots are: start (line low), data bit 0 through data bit 7, parity, and stop (line released). `io_drive_low` is 1 exactly when the current slot value is 0.
- R2: The parity slot carries XOR(data bits) XOR `odd_parity`. With `odd_parity`=0 the number of ones over data plus parity is even. With `odd_parity`=1 it is odd. The same rule is used to check received characters.
- R3: The transmit queue holds 8 bytes. A `tx_wr` while `tx_full`=1 is ignored, and `tx_overflow` is high for exactly one cycle in the cycle after that write.
- R4: A received character with a valid start is rebuilt with the first data slot as bit 0. It is queued, shown on `rx_data` while `st_data_ready`=1, and removed by a one-cycle `rx_rd`. Bytes come out in arrival order.
- R5: A low pulse that is gone by the middle of the start slot produces no byte and no error flag.
- R6: A received parity slot that breaks the R2 rule sets `st_parity_err`. The byte is still queued.
- R7: A stop slot sampled low sets `st_frame_err`. The byte is still queued.
- R8: A character that completes while the receive queue holds 8 bytes is dropped and sets `st_overrun`. The 8 queued bytes are unchanged.
- R9: `st_parity_err`, `st_frame_err` and `st_overrun` stay set until `err_clear` is pulsed. A pulse of `err_clear` clears them.
- R10: The receiver ignores the line while a character is being transmitted, so the block's own characters are never received. A queued transmit byte waits until the receiver has finished an incoming character.
- R11: `st_tx_empty` is 1 only when the transmit queue is empty and no character is being shifted out.
- R12: After reset the line is released, `st_tx_empty`=1, `st_data_ready`=0, and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; slot length is counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_cycles | input | ETU_W | Slot length in clock cycles (minimum 2) |
| odd_parity | input | 1 | 0 even parity, 1 odd parity |
| err_clear | input | 1 | Pulse that clears the sticky error flags |
| tx_wr | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue holds 8 bytes |
| tx_overflow | output | 1 | One-cycle pulse after a write to a full queue |
| rx_rd | input | 1 | Remove the head byte of the receive queue |
| rx_data | output | 8 | Head byte of the receive queue |
| io_in | input | 1 | Sampled level of the data line |
| io_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| st_data_ready | output | 1 | Receive queue is not empty |
| st_parity_err | output | 1 | Sticky parity error |
| st_frame_err | output | 1 | Sticky stop-slot error |
| st_overrun | output | 1 | Sticky receive overrun |
| st_tx_empty | output | 1 | Transmit queue empty and transmitter idle |

## Verification
Two functions can fall on the same cycle. In the first, a byte can be written to the transmit queue while an incoming character is being sampled. The bench starts a card character, writes a transmit byte two slots into it, and requires the line drive to stay released until the incoming byte has arrived intact. The scoreboard then requires the transmit byte to appear correctly afterwards. In the second, a completing character can meet a full receive queue. The bench withholds reads, sends nine characters, and then requires `st_overrun` to be set while exactly the first eight bytes drain in order.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;

  localparam int CHAR_SLOTS = 11;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_t;

  // parity slot value for a byte under the selected sense
  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // the assembled character, slot 0 first at the LSB
  function automatic logic [CHAR_SLOTS-1:0] build_char(input logic [7:0] d, input logic odd);
    return {1'b1, parity_of(d, odd), d, 1'b0};
  endfunction

endpackage

// File: rtl/sc_fifo.sv
module sc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/sc_tx_engine.sv
module sc_tx_engine
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] etu,
  input  logic             odd,
  input  logic             start_ok,
  input  logic [7:0]       data,
  output logic             pop,
  output logic             busy,
  output logic             drive_low
);
  localparam logic [3:0] LAST_SLOT = 4'(CHAR_SLOTS - 1);

  logic [CHAR_SLOTS-1:0] shreg;
  logic [3:0]            slot;
  logic [ETU_W-1:0]      tick;
  logic                  slot_end;

  assign pop       = !busy && start_ok;
  assign slot_end  = (tick == etu - 1'b1);
  assign drive_low = busy && !shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      slot  <= '0;
      tick  <= '0;
    end else if (pop) begin
      busy  <= 1'b1;
      shreg <= build_char(data, odd);
      slot  <= '0;
      tick  <= '0;
    end else if (busy) begin
      if (slot_end) begin
        tick <= '0;
        if (slot == LAST_SLOT) begin
          busy <= 1'b0;
        end else begin
          slot  <= slot + 1'b1;
          shreg <= {1'b1, shreg[CHAR_SLOTS-1:1]};
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_rx_engine.sv
module sc_rx_engine
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] etu,
  input  logic             odd,
  input  logic             enable,
  input  logic             line,
  input  logic             q_full,
  output logic             push,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             stop_ev,
  output logic             par_err_ev,
  output logic             frm_err_ev,
  output logic             ovr_ev
);
  localparam logic [3:0] STOP_IDX = 4'd9;

  rx_state_t        state;
  logic [ETU_W-1:0] tick;
  logic [3:0]       idx;
  logic [8:0]       shreg;
  logic             mid_start, mid_slot;

  assign mid_start  = (state == RX_START) && (tick == (etu >> 1) - 1'b1);
  assign mid_slot   = (state == RX_BITS) && (tick == etu - 1'b1);
  assign stop_ev    = mid_slot && (idx == STOP_IDX);
  assign push       = stop_ev && !q_full;
  assign ovr_ev     = stop_ev && q_full;
  assign par_err_ev = stop_ev && (shreg[8] != parity_of(shreg[7:0], odd));
  assign frm_err_ev = stop_ev && !line;
  assign rx_byte    = shreg[7:0];
  assign busy       = (state != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      tick  <= '0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          tick <= '0;
          if (enable && !line) state <= RX_START;
        end
        RX_START: begin
          if (mid_start) begin
            tick  <= '0;
            idx   <= '0;
            state <= line ? RX_IDLE : RX_BITS;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        RX_BITS: begin
          if (mid_slot) begin
            tick <= '0;
            if (idx == STOP_IDX) begin
              state <= RX_IDLE;
            end else begin
              shreg <= {line, shreg[8:1]};
              idx   <= idx + 1'b1;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_xcvr_pkg::*;
#(
  parameter int ETU_W   = 16,
  parameter int Q_DEPTH = 8,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] etu_cycles,
  input  logic             odd_parity,
  input  logic             err_clear,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_full,
  output logic             tx_overflow,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  input  logic             io_in,
  output logic             io_drive_low,
  output logic             st_data_ready,
  output logic             st_parity_err,
  output logic             st_frame_err,
  output logic             st_overrun,
  output logic             st_tx_empty
);
  logic [SYNC_N-1:0] sync_q;
  logic       line_s;
  logic       txq_empty, txq_pop;
  logic [7:0] txq_head;
  logic       tx_busy, tx_start_ok;
  logic       rxq_full, rxq_empty, rx_push;
  logic [7:0] rx_byte;
  logic       rx_busy, rx_stop_ev, par_ev, frm_ev, ovr_ev;

  // line synchroniser, idles released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], io_in};
  end
  assign line_s = sync_q[SYNC_N-1];

  sc_fifo #(.W(8), .DEPTH(Q_DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_data),
    .pop(txq_pop), .rdata(txq_head), .full(tx_full), .empty(txq_empty)
  );

  assign tx_start_ok = !txq_empty && !rx_busy;

  sc_tx_engine #(.ETU_W(ETU_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .etu(etu_cycles), .odd(odd_parity),
    .start_ok(tx_start_ok), .data(txq_head), .pop(txq_pop),
    .busy(tx_busy), .drive_low(io_drive_low)
  );

  sc_rx_engine #(.ETU_W(ETU_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .etu(etu_cycles), .odd(odd_parity),
    .enable(!tx_busy), .line(line_s), .q_full(rxq_full),
    .push(rx_push), .rx_byte(rx_byte), .busy(rx_busy), .stop_ev(rx_stop_ev),
    .par_err_ev(par_ev), .frm_err_ev(frm_ev), .ovr_ev(ovr_ev)
  );

  sc_fifo #(.W(8), .DEPTH(Q_DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
    .pop(rx_rd), .rdata(rx_data), .full(rxq_full), .empty(rxq_empty)
  );

  // sticky error flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_parity_err <= 1'b0;
      st_frame_err  <= 1'b0;
      st_overrun    <= 1'b0;
      tx_overflow   <= 1'b0;
    end else begin
      st_parity_err <= par_ev || (st_parity_err && !err_clear);
      st_frame_err  <= frm_ev || (st_frame_err && !err_clear);
      st_overrun    <= ovr_ev || (st_overrun && !err_clear);
      tx_overflow   <= tx_wr && tx_full;
    end
  end

  assign st_data_ready = !rxq_empty;
  assign st_tx_empty   = txq_empty && !tx_busy;
endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic err_clear,
  input logic tx_wr,
  input logic tx_full,
  input logic tx_overflow,
  input logic io_drive_low,
  input logic tx_busy,
  input logic rx_busy,
  input logic rx_stop_ev,
  input logic rxq_full,
  input logic st_overrun,
  input logic st_parity_err,
  input logic st_frame_err,
  input logic st_tx_empty
);
  // R1
  drive_in_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_drive_low |-> tx_busy);

  // R10
  half_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_drive_low |-> !rx_busy);

  // R3
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |-> $past(tx_wr && tx_full));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stop_ev && rxq_full) |=> st_overrun);

  // R9
  parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_parity_err && !err_clear) |=> st_parity_err);

  // R9
  frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_frame_err && !err_clear) |=> st_frame_err);

  // R11
  tx_empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_tx_empty |-> !io_drive_low);
endmodule

bind sc_char_xcvr sc_char_xcvr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .err_clear(err_clear), .tx_wr(tx_wr),
  .tx_full(tx_full), .tx_overflow(tx_overflow), .io_drive_low(io_drive_low),
  .tx_busy(tx_busy), .rx_busy(rx_busy), .rx_stop_ev(rx_stop_ev),
  .rxq_full(rxq_full), .st_overrun(st_overrun), .st_parity_err(st_parity_err),
  .st_frame_err(st_frame_err), .st_tx_empty(st_tx_empty)
);

// File: tb/test_sc_char_xcvr.sv
`timescale 1ns/1ps
module test_sc_char_xcvr;
  localparam int ETU = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] etu_cycles = 16'(ETU);
  logic odd_parity = 1'b0, err_clear = 1'b0;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_full, tx_overflow, io_drive_low;
  logic [7:0] rx_data;
  logic st_data_ready, st_parity_err, st_frame_err, st_overrun, st_tx_empty;
  logic card_drv = 1'b0;
  logic line;

  assign line = !(io_drive_low || card_drv);

  always #4 clk = ~clk;

  sc_char_xcvr i_sc_char_xcvr (
    .clk(clk), .rst_n(rst_n), .etu_cycles(etu_cycles), .odd_parity(odd_parity),
    .err_clear(err_clear), .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
    .tx_overflow(tx_overflow), .rx_rd(rx_rd), .rx_data(rx_data), .io_in(line),
    .io_drive_low(io_drive_low), .st_data_ready(st_data_ready),
    .st_parity_err(st_parity_err), .st_frame_err(st_frame_err),
    .st_overrun(st_overrun), .st_tx_empty(st_tx_empty)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, rx_auto = 1'b1, tx_mon_busy = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // card-side decoder for transmitted characters
  initial begin
    forever begin
      @(negedge clk);
      if (io_drive_low) begin
        logic [9:0] bits;
        logic [7:0] e;
        tx_mon_busy = 1'b1;
        repeat (ETU/2) @(negedge clk);
        chk(line == 1'b0, "R1 start slot", int'(line), 0);
        for (int k = 0; k < 10; k++) begin
          repeat (ETU) @(negedge clk);
          bits[k] = line;
        end
        if (exp_tx.size() == 0) begin
          chk(1'b0, "R1 unexpected char", int'(bits[7:0]), 0);
        end else begin
          e = exp_tx.pop_front();
          chk(bits[7:0] == e, "R1 data", int'(bits[7:0]), int'(e));
          chk(bits[8] == ((^e) ^ odd_parity), "R2 parity slot", int'(bits[8]), int'((^e) ^ odd_parity));
          chk(bits[9] == 1'b1, "R1 stop slot", int'(bits[9]), 1);
        end
        tx_mon_busy = 1'b0;
      end
    end
  end

  // receive scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rx_auto && st_data_ready) begin
        if (exp_rx.size() == 0) begin
          chk(1'b0, "R4 unexpected byte", int'(rx_data), 0);
        end else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          chk(rx_data == e, "R4 received byte", int'(rx_data), int'(e));
        end
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
      end
    end
  end

  task automatic tx_push(input logic [7:0] d);
    @(negedge clk);
    tx_wr = 1'b1;
    tx_data = d;
    exp_tx.push_back(d);
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic tx_drain();
    do @(negedge clk); while (exp_tx.size() != 0 || tx_mon_busy || !st_tx_empty);
  endtask

  task automatic card_send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [10:0] c;
    c = {!bad_stop, (^d) ^ odd_parity ^ bad_par, d, 1'b0};
    for (int k = 0; k < 11; k++) begin
      card_drv = !c[k];
      repeat (ETU) @(negedge clk);
    end
    card_drv = 1'b0;
  endtask

  task automatic clear_errs();
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(io_drive_low == 1'b0, "R12 line released", int'(io_drive_low), 0);
    chk(st_tx_empty == 1'b1, "R12 tx empty", int'(st_tx_empty), 1);
    chk(st_data_ready == 1'b0, "R12 no data", int'(st_data_ready), 0);
    chk({st_parity_err, st_frame_err, st_overrun} == 3'b000, "R12 flags", int'({st_parity_err, st_frame_err, st_overrun}), 0);

    // R1 R2 even parity transmit, R11 not empty while pending
    tx_push(8'hA5);
    chk(st_tx_empty == 1'b0, "R11 pending byte", int'(st_tx_empty), 0);
    tx_drain();
    chk(st_tx_empty == 1'b1, "R11 idle again", int'(st_tx_empty), 1);

    // R2 odd parity transmit
    odd_parity = 1'b1;
    tx_push(8'h3C);
    tx_drain();
    odd_parity = 1'b0;

    // R3 burst of ten: nine accepted, tenth dropped
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 9) chk(tx_overflow == 1'b0, "R3 no early overflow", int'(tx_overflow), 0);
      tx_wr = 1'b1;
      tx_data = 8'(8'h10 + i * 7);
      if (i < 9) exp_tx.push_back(8'(8'h10 + i * 7));
    end
    @(negedge clk);
    tx_wr = 1'b0;
    chk(tx_overflow == 1'b1, "R3 overflow pulse", int'(tx_overflow), 1);
    @(negedge clk);
    chk(tx_overflow == 1'b0, "R3 pulse one cycle", int'(tx_overflow), 0);
    tx_drain();
    // R10 own characters never received
    chk(st_data_ready == 1'b0, "R10 own chars ignored", int'(st_data_ready), 0);

    // R4 receive
    exp_rx.push_back(8'h5A); card_send(8'h5A, 1'b0, 1'b0);
    exp_rx.push_back(8'h81); card_send(8'h81, 1'b0, 1'b0);
    odd_parity = 1'b1;
    exp_rx.push_back(8'h7E); card_send(8'h7E, 1'b0, 1'b0);
    odd_parity = 1'b0;
    repeat (ETU) @(negedge clk);
    chk(exp_rx.size() == 0, "R4 all bytes out", exp_rx.size(), 0);
    chk({st_parity_err, st_frame_err} == 2'b00, "R2 good parity accepted", int'({st_parity_err, st_frame_err}), 0);

    // R5 false start
    card_drv = 1'b1;
    repeat (ETU/4) @(negedge clk);
    card_drv = 1'b0;
    repeat (3*ETU) @(negedge clk);
    chk(st_data_ready == 1'b0, "R5 glitch no byte", int'(st_data_ready), 0);
    chk({st_parity_err, st_frame_err} == 2'b00, "R5 glitch no flag", int'({st_parity_err, st_frame_err}), 0);

    // R6 parity error, R9 sticky then cleared
    exp_rx.push_back(8'hC3); card_send(8'hC3, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk(st_parity_err == 1'b1, "R6 parity error", int'(st_parity_err), 1);
    chk(st_frame_err == 1'b0, "R6 no frame error", int'(st_frame_err), 0);
    repeat (3*ETU) @(negedge clk);
    chk(st_parity_err == 1'b1, "R9 flag holds", int'(st_parity_err), 1);
    chk(exp_rx.size() == 0, "R6 byte kept", exp_rx.size(), 0);
    clear_errs();
    chk(st_parity_err == 1'b0, "R9 cleared", int'(st_parity_err), 0);

    // R7 frame error
    exp_rx.push_back(8'h24); card_send(8'h24, 1'b0, 1'b1);
    repeat (3*ETU) @(negedge clk);
    chk(st_frame_err == 1'b1, "R7 frame error", int'(st_frame_err), 1);
    chk(exp_rx.size() == 0, "R7 byte kept", exp_rx.size(), 0);
    clear_errs();
    chk(st_frame_err == 1'b0, "R9 frame cleared", int'(st_frame_err), 0);

    // R8 overrun: nine chars with no reads
    rx_auto = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (i < 8) exp_rx.push_back(8'(8'h40 + i * 3));
      card_send(8'(8'h40 + i * 3), 1'b0, 1'b0);
    end
    repeat (2) @(negedge clk);
    chk(st_overrun == 1'b1, "R8 overrun flag", int'(st_overrun), 1);
    rx_auto = 1'b1;
    repeat (40) @(negedge clk);
    chk(exp_rx.size() == 0, "R8 eight bytes intact", exp_rx.size(), 0);
    chk(st_data_ready == 1'b0, "R8 ninth dropped", int'(st_data_ready), 0);
    clear_errs();
    chk(st_overrun == 1'b0, "R9 overrun cleared", int'(st_overrun), 0);

    // R10 transmit waits for an incoming character
    exp_rx.push_back(8'h96);
    fork
      card_send(8'h96, 1'b0, 1'b0);
      begin
        bit quiet;
        quiet = 1'b1;
        repeat (2*ETU) @(negedge clk);
        tx_push(8'h6B);
        repeat (8*ETU) begin
          @(negedge clk);
          if (io_drive_low) quiet = 1'b0;
        end
        chk(quiet, "R10 tx held during rx", int'(quiet), 1);
      end
    join
    tx_drain();
    repeat (ETU) @(negedge clk);
    chk(exp_rx.size() == 0, "R10 incoming byte intact", exp_rx.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule